// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Command Controller

This block sits on the host side of a three-wire serial EEPROM link holding 64 words of 16 bits. A client hands it one command at a time over a valid/ready request port: a 3-bit command code, a 6-bit word address and a 16-bit write word. The block then drives the memory's select line, a shift clock divided down from the system clock and the serial data line. For reads it collects the word returned on the memory's data output.

Every transfer opens with a start bit, a 2-bit wire opcode and six address bits. Global commands reuse opcode 00 and carry their selector in the upper two address bits. Read data is preceded by a zero that the block throws away. Commands that program the array end with a busy/ready poll: select is dropped for a minimum time, raised again, and the data output is watched until it goes high or a cycle limit runs out. Completion is a one-cycle `done` pulse with `err` and `rd_data` valid beside it. Only one command is in flight at any time.

Top module: `uwire_host`

## Requirements
- R1: Every frame starts with a 1, followed by the wire opcode (MSB first) and then the six address bits (MSB first). The wire opcode is 10 for read (code 0), 01 for write (code 1) and 11 for erase (code 2).
- R2: Program-enable (code 3), program-disable (code 4), erase-all (code 5) and write-all (code 6) send wire opcode 00. The top two address bits carry 11, 00, 10 and 01 respectively and the lower four are 0. Frames for codes 2 to 5 last exactly 9 shift-clock cycles.
- R3: Write and write-all frames append the 16 data bits MSB first and last exactly 25 shift-clock cycles. A read frame also lasts 25 cycles and sends 0 after the address.
- R4: On a read, the bit returned in the ninth shift cycle (the dummy 0) is discarded. At `done`, `rd_data` holds the next 16 returned bits, MSB first.
- R5: Each shift-clock phase lasts HALF_CYC system cycles. The shift clock toggles only while select is high. Serial data changes only while the clock is low. The data output is sampled in the last system cycle of each high phase.
- R6: Select stays low for at least CSL_CYC system cycles before every frame and before every status poll.
- R7: After a program-type frame (codes 1, 2, 5, 6), select is raised again without clocking. When the data output reads 1, the block finishes with `err`=0 and drops select.
- R8: If the data output stays 0 for POLL_LIMIT cycles of polling, the block finishes with `err`=1.
- R9: Code 7 is unknown. It finishes on the next cycle with `err`=1, and select never rises.
- R10: `req_ready` is high only when idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `done` is a single-cycle pulse.
- R11: After reset, select, shift clock and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Block idle and accepting |
| req_op | input | 3 | Command code (0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase-all, 6 write-all) |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Write word |
| done | output | 1 | Command finished (one cycle) |
| err | output | 1 | Timeout or unknown command, valid with done |
| rd_data | output | 16 | Word returned by the last read |
| mem_sel | output | 1 | Memory chip select |
| mem_clk | output | 1 | Memory shift clock |
| mem_din | output | 1 | Serial data to memory |
| mem_dout | input | 1 | Serial data / status from memory |

## Verification
A wrong frame-slot count or a bad shift-register state shows up when select falls, within the same command: the frame observed by the memory model has the wrong length or the wrong bits, and a read returns a word shifted by one position. A broken wait or poll counter shows up before the next frame starts: select rises too early, or `done` arrives with the wrong `err`. The latest point at which it can show is the poll limit. Because the behavioural memory applies what it decodes, errors in programming frames also surface later, as wrong data on subsequent reads.

// File: rtl/uwh_pkg.sv
package uwh_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;
  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int SLOT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    CMD_READ = 3'd0, CMD_WRITE = 3'd1, CMD_ERASE = 3'd2, CMD_PROG_ON = 3'd3,
    CMD_PROG_OFF = 3'd4, CMD_ERASE_ALL = 3'd5, CMD_WRITE_ALL = 3'd6, CMD_RSVD = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_FRAME, S_GAP, S_POLL, S_FIN
  } st_e;

  function automatic logic cmd_known(cmd_e c);
    return c != CMD_RSVD;
  endfunction

  function automatic logic cmd_polls(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) ||
           (c == CMD_ERASE_ALL) || (c == CMD_WRITE_ALL);
  endfunction

  function automatic logic [SLOT_W-1:0] frame_slots(cmd_e c);
    if (c == CMD_READ || c == CMD_WRITE || c == CMD_WRITE_ALL)
      return SLOT_W'(FRAME_W);
    return SLOT_W'(HDR_W);
  endfunction

  // Left-aligned frame image; the first bit on the wire is the MSB.
  function automatic logic [FRAME_W-1:0] frame_word(cmd_e c, logic [ADDR_W-1:0] a,
                                                    logic [DATA_W-1:0] d);
    logic [1:0]        opc;
    logic [ADDR_W-1:0] fa;
    logic [DATA_W-1:0] fd;
    opc = 2'b00;
    fa  = a;
    fd  = '0;
    case (c)
      CMD_READ:      opc = 2'b10;
      CMD_WRITE:     begin opc = 2'b01; fd = d; end
      CMD_ERASE:     opc = 2'b11;
      CMD_PROG_ON:   fa = {2'b11, {(ADDR_W-2){1'b0}}};
      CMD_PROG_OFF:  fa = {2'b00, {(ADDR_W-2){1'b0}}};
      CMD_ERASE_ALL: fa = {2'b10, {(ADDR_W-2){1'b0}}};
      CMD_WRITE_ALL: begin fa = {2'b01, {(ADDR_W-2){1'b0}}}; fd = d; end
      default:       ;
    endcase
    return {1'b1, opc, fa, fd};
  endfunction
endpackage

// File: rtl/uwh_sclk.sv
module uwh_sclk #(
  parameter int HALF_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sk,
  output logic slot_end
);
  localparam int HALF_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HALF_W-1:0] CNT_LAST = HALF_W'(HALF_CYC - 1);

  logic [HALF_W-1:0] cnt;
  logic              ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (cnt == CNT_LAST) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sk       = ph;
  assign slot_end = run && ph && (cnt == CNT_LAST);
endmodule

// File: rtl/uwh_rxcap.sv
module uwh_rxcap #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (clear) word <= '0;
    else if (shift) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/uwire_host.sv
module uwire_host
  import uwh_pkg::*;
#(
  parameter int HALF_CYC   = 25,
  parameter int CSL_CYC    = 25,
  parameter int POLL_LIMIT = 1_100_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [5:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        done,
  output logic        err,
  output logic [15:0] rd_data,
  output logic        mem_sel,
  output logic        mem_clk,
  output logic        mem_din,
  input  logic        mem_dout
);
  localparam int CSL_W  = $clog2(CSL_CYC + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CSL_W-1:0]  CSL_LAST  = CSL_W'(CSL_CYC - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);
  localparam logic [SLOT_W-1:0] HDR_SLOTS = SLOT_W'(HDR_W);

  st_e                 st;
  cmd_e                op_q;
  cmd_e                req_cmd;
  logic [FRAME_W-1:0]  shreg;
  logic [SLOT_W-1:0]   slot_q, last_q;
  logic [CSL_W-1:0]    wait_q;
  logic [POLL_W-1:0]   pcnt;
  logic                err_q;

  // named internal events
  logic in_frame, in_poll, slot_end, accept, cap_shift;

  assign req_cmd   = cmd_e'(req_op);
  assign in_frame  = (st == S_FRAME);
  assign in_poll   = (st == S_POLL);
  assign accept    = (st == S_IDLE) && req_valid;
  assign cap_shift = in_frame && slot_end && (op_q == CMD_READ) && (slot_q >= HDR_SLOTS);

  uwh_sclk #(.HALF_CYC(HALF_CYC)) i_sclk (
    .clk(clk), .rst_n(rst_n), .run(in_frame), .sk(mem_clk), .slot_end(slot_end)
  );

  uwh_rxcap #(.W(DATA_W)) i_rxcap (
    .clk(clk), .rst_n(rst_n), .clear(accept && req_cmd == CMD_READ),
    .shift(cap_shift), .bit_in(mem_dout), .word(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= CMD_READ;
      shreg  <= '0;
      slot_q <= '0;
      last_q <= '0;
      wait_q <= '0;
      pcnt   <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_q   <= req_cmd;
          shreg  <= frame_word(req_cmd, req_addr, req_wdata);
          slot_q <= '0;
          last_q <= frame_slots(req_cmd) - SLOT_W'(1);
          wait_q <= '0;
          pcnt   <= '0;
          err_q  <= !cmd_known(req_cmd);
          st     <= cmd_known(req_cmd) ? S_PRE : S_FIN;
        end
        S_PRE, S_GAP: begin
          if (wait_q == CSL_LAST) begin
            wait_q <= '0;
            st     <= (st == S_PRE) ? S_FRAME : S_POLL;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        S_FRAME: if (slot_end) begin
          shreg <= {shreg[FRAME_W-2:0], 1'b0};
          if (slot_q == last_q) st <= cmd_polls(op_q) ? S_GAP : S_FIN;
          else                  slot_q <= slot_q + 1'b1;
        end
        S_POLL: begin
          if (mem_dout) begin
            st <= S_FIN;
          end else if (pcnt == POLL_LAST) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_FIN);
  assign err       = err_q;
  assign mem_sel   = in_frame || in_poll;
  assign mem_din   = in_frame && shreg[FRAME_W-1];
endmodule

// File: rtl/uwire_host_chk.sv
module uwire_host_chk #(
  parameter int HALF_CYC   = 25,
  parameter int CSL_CYC    = 25,
  parameter int POLL_LIMIT = 1_100_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_op,
  input logic       done,
  input logic       err,
  input logic       mem_sel,
  input logic       mem_clk,
  input logic       mem_din,
  input logic       mem_dout,
  input logic       in_poll
);
  localparam int LW = $clog2(CSL_CYC + 1) + 1;
  localparam int PW = $clog2(POLL_LIMIT + 1) + 1;
  localparam int HW = $clog2(HALF_CYC + 1) + 1;

  logic [LW-1:0] low_run;
  logic [PW-1:0] poll_run;
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      poll_run <= '0;
      hi_run   <= '0;
    end else begin
      low_run  <= mem_sel ? '0 : ((low_run == '1) ? low_run : low_run + 1'b1);
      poll_run <= in_poll ? ((poll_run == '1) ? poll_run : poll_run + 1'b1) : '0;
      hi_run   <= mem_clk ? ((hi_run == '1) ? hi_run : hi_run + 1'b1) : '0;
    end
  end

  AST_CLK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clk |-> mem_sel);                                                   // R5
  AST_DIN_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_clk && $past(mem_clk)) |-> $stable(mem_din));                      // R5
  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clk |-> (hi_run < HW'(HALF_CYC)));                                  // R5
  AST_SEL_LOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sel) |-> (low_run >= LW'(CSL_CYC)));                          // R6
  AST_POLL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_poll && mem_dout) |=> (done && !err && !mem_sel));                  // R7
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_poll |-> (poll_run < PW'(POLL_LIMIT)));                              // R8
  AST_BAD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 3'd7) |=> (done && err && !mem_sel)); // R9
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_sel);                                                // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                        // R10
endmodule

bind uwire_host uwire_host_chk #(
  .HALF_CYC(HALF_CYC), .CSL_CYC(CSL_CYC), .POLL_LIMIT(POLL_LIMIT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .done(done), .err(err), .mem_sel(mem_sel), .mem_clk(mem_clk),
  .mem_din(mem_din), .mem_dout(mem_dout), .in_poll(in_poll)
);

// File: tb/test_uwire_host.sv
module test_uwire_host;
  localparam int HALF = 2;
  localparam int CSL  = 25;
  localparam int PLIM = 3000;
  localparam int BUSY = 300;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_ready, done, err, mem_sel, mem_clk, mem_din, mem_dout;
  logic [2:0]  req_op;
  logic [5:0]  req_addr;
  logic [15:0] req_wdata, rd_data;

  uwire_host #(.HALF_CYC(HALF), .CSL_CYC(CSL), .POLL_LIMIT(PLIM)) i_uwire_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
    .err(err), .rd_data(rd_data), .mem_sel(mem_sel), .mem_clk(mem_clk),
    .mem_din(mem_din), .mem_dout(mem_dout)
  );

  int checks = 0, errors = 0;

  // ---------------- behavioural memory ----------------
  logic [15:0] mem_a [64];
  logic        wen, stuck, prev_sk, prev_cs, rbit;
  int          busy, bitcnt, sessions, low_run, min_gap, hi_run, phase_bad, last_len;
  logic [24:0] bits, last_bits, nb;
  logic [15:0] rword;
  int          nc;

  function automatic logic [15:0] init_word(int i);
    return 16'(i * 257) ^ 16'h5a5a;
  endfunction

  assign mem_dout = mem_sel ? ((bitcnt == 0) ? (busy == 0 && !stuck) : rbit) : 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem_a[i] <= init_word(i);
      wen <= 0; busy <= 0; bitcnt <= 0; bits <= 0; sessions <= 0;
      prev_sk <= 0; prev_cs <= 0; rbit <= 0; rword <= 0;
      low_run <= 0; min_gap <= 1 << 30; hi_run <= 0; phase_bad <= 0;
      last_len <= 0; last_bits <= 0;
    end else begin
      prev_sk <= mem_clk;
      prev_cs <= mem_sel;
      if (busy > 0) busy <= busy - 1;
      if (!mem_sel) low_run <= low_run + 1;
      else begin
        if (!prev_cs) begin
          sessions <= sessions + 1;
          if (low_run < min_gap) min_gap <= low_run;
        end
        low_run <= 0;
      end
      if (mem_clk) hi_run <= hi_run + 1;
      else begin
        if (prev_sk && hi_run != HALF) phase_bad <= phase_bad + 1;
        hi_run <= 0;
      end
      if (mem_sel && mem_clk && !prev_sk) begin
        nb = {bits[23:0], mem_din};
        nc = bitcnt + 1;
        bits   <= nb;
        bitcnt <= nc;
        if (nc == 9) begin rword <= mem_a[nb[5:0]]; rbit <= 1'b0; end
        else if (nc > 9 && nc <= 25) rbit <= rword[25 - nc];
      end
      if (!mem_sel && prev_cs && bitcnt > 0) begin
        last_bits <= bits; last_len <= bitcnt; bitcnt <= 0; bits <= 0;
        if (bitcnt == 9) begin
          if (bits[7:6] == 2'b11 && wen) begin mem_a[bits[5:0]] <= 16'hffff; busy <= BUSY; end
          if (bits[7:6] == 2'b00) begin
            if (bits[5:4] == 2'b11) wen <= 1'b1;
            if (bits[5:4] == 2'b00) wen <= 1'b0;
            if (bits[5:4] == 2'b10 && wen) begin
              for (int i = 0; i < 64; i++) mem_a[i] <= 16'hffff;
              busy <= BUSY;
            end
          end
        end else if (bitcnt == 25 && wen) begin
          if (bits[23:22] == 2'b01) begin mem_a[bits[21:16]] <= bits[15:0]; busy <= BUSY; end
          if (bits[23:22] == 2'b00 && bits[21:20] == 2'b01) begin
            for (int i = 0; i < 64; i++) mem_a[i] <= bits[15:0];
            busy <= BUSY;
          end
        end
      end
    end
  end

  // ---------------- bench reference ----------------
  logic [15:0] exp_mem [64];
  logic        exp_wen;

  function automatic int exp_len(logic [2:0] op);
    return (op == 3'd0 || op == 3'd1 || op == 3'd6) ? 25 : 9;
  endfunction

  function automatic logic [24:0] exp_frame(logic [2:0] op, logic [5:0] a, logic [15:0] d);
    logic [8:0] h;
    case (op)
      3'd0: h = {3'b110, a};
      3'd1: h = {3'b101, a};
      3'd2: h = {3'b111, a};
      3'd3: h = 9'b100_110000;
      3'd4: h = 9'b100_000000;
      3'd5: h = 9'b100_100000;
      default: h = 9'b100_010000;
    endcase
    if (op == 3'd1 || op == 3'd6) return {h, d};
    if (op == 3'd0) return {h, 16'h0000};
    return {16'h0000, h};
  endfunction

  function automatic logic is_prog(logic [2:0] op);
    return op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(logic [2:0] op, logic [5:0] a, logic [15:0] d);
    int s0, waitc;
    logic ee;
    @(negedge clk);
    chk("R10 ready before request", {31'b0, req_ready}, 1);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    s0 = sessions;
    @(negedge clk);
    req_valid = 0;
    chk("R10 ready low while busy", {31'b0, req_ready}, 0);
    waitc = 0;
    while (!done && waitc < 20000) begin @(negedge clk); waitc++; end
    chk("R10 done reached", {31'b0, done}, 1);
    ee = (op == 3'd7) || (stuck && is_prog(op));
    if (op == 3'd7) chk("R9 unknown code err", {31'b0, err}, 1);
    else if (stuck && is_prog(op)) begin
      chk("R8 timeout err", {31'b0, err}, 1);
      chk("R8 timeout duration", {31'b0, waitc >= PLIM}, 1);
    end else if (is_prog(op)) chk("R7 poll ok err", {31'b0, err}, {31'b0, ee});
    else chk("R1 err clear", {31'b0, err}, 0);
    if (op == 3'd0) chk("R4 read data", {16'b0, rd_data}, {16'b0, exp_mem[a]});
    @(negedge clk);
    chk("R10 done single pulse", {31'b0, done}, 0);
    if (op == 3'd7) chk("R9 no select activity", sessions, s0);
    else begin
      chk(exp_len(op) == 25 ? "R3 frame length" : "R2 frame length", last_len, exp_len(op));
      chk(op <= 3'd2 ? "R1 frame bits" : "R2 frame bits", {7'b0, last_bits}, {7'b0, exp_frame(op, a, d)});
      chk("R7 poll session count", sessions, s0 + (is_prog(op) ? 2 : 1));
    end
    case (op)
      3'd1: if (exp_wen) exp_mem[a] = d;
      3'd2: if (exp_wen) exp_mem[a] = 16'hffff;
      3'd3: exp_wen = 1;
      3'd4: exp_wen = 0;
      3'd5: if (exp_wen) for (int i = 0; i < 64; i++) exp_mem[i] = 16'hffff;
      3'd6: if (exp_wen) for (int i = 0; i < 64; i++) exp_mem[i] = d;
      default: ;
    endcase
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [2:0] rop;
    req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0; stuck = 0; rst_n = 0;
    seed = $urandom(32'd4711);
    for (int i = 0; i < 64; i++) exp_mem[i] = init_word(i);
    exp_wen = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset select", {31'b0, mem_sel}, 0);
    chk("R11 reset clock", {31'b0, mem_clk}, 0);
    chk("R11 reset done", {31'b0, done}, 0);
    chk("R11 reset ready", {31'b0, req_ready}, 1);

    do_cmd(3'd0, 6'd0, 16'h0);
    do_cmd(3'd1, 6'd9, 16'h1234);   // disabled: no change
    do_cmd(3'd0, 6'd9, 16'h0);
    do_cmd(3'd3, 6'd0, 16'h0);
    do_cmd(3'd1, 6'd63, 16'h8001);
    do_cmd(3'd0, 6'd63, 16'h0);
    do_cmd(3'd2, 6'd63, 16'h0);
    do_cmd(3'd0, 6'd63, 16'h0);
    do_cmd(3'd6, 6'd0, 16'ha5c3);
    do_cmd(3'd0, 6'd17, 16'h0);
    do_cmd(3'd5, 6'd0, 16'h0);
    do_cmd(3'd0, 6'd40, 16'h0);
    do_cmd(3'd7, 6'd3, 16'h0);
    do_cmd(3'd1, 6'd2, 16'h0001);
    do_cmd(3'd0, 6'd2, 16'h0);
    stuck = 1;
    do_cmd(3'd1, 6'd5, 16'hbeef);
    stuck = 0;
    do_cmd(3'd0, 6'd5, 16'h0);
    for (int n = 0; n < 40; n++) begin
      rop = 3'($urandom % 8);
      if ((rop == 3'd5 || rop == 3'd6) && ($urandom % 3) != 0) rop = 3'd0;
      do_cmd(rop, 6'($urandom), 16'($urandom));
    end
    chk("R6 minimum select low gap", {31'b0, min_gap >= CSL}, 1);
    chk("R5 high phase length", phase_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule